// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Read

This block is a 16-bit up-counter that runs freely and wraps from 0xFFFF to 0x0000. Its count clock comes from a prescaler, which offers seven power-of-two divisions of the bus clock. It can instead take rising edges of an external clock pin. Software controls the block through an 8-bit register bus with three locations: a control register, the upper count byte and the lower count byte. The control register can stop the counter. It can also clear the counter and the prescaler together, using a bit that never holds a value.

The count cannot be read in one access, so a read of the upper byte copies the live lower byte into a holding buffer. A later read of the lower byte returns that copy and releases the buffer. The two byte reads therefore form one 16-bit value, even when the counter moves between them.

Register reads are combinational: `rd_data` shows the addressed location during the same cycle as `rd_en`. Any side effect of the read takes place at the next clock edge. Writes take effect at the clock edge on which `wr_en` is sampled high.

Top module: `ptmr_timer`

## Requirements
- R1: After a synchronous reset, the upper count byte (address 1), the lower count byte (address 2) and the control register (address 0) all read 0x00.
- R2: Control bits [2:0] select the count rate. A code k from 0 to 6 gives one increment every 2^k bus cycles. After a clear, the count equals floor(N / 2^k) once N bus cycles have run without a stop.
- R3: Code 7 in control bits [2:0] selects the external clock pin. Each rising edge of the pin, after two synchronizing flops, adds exactly one to the count.
- R4: While control bit 3 (stop) is 1, both the counter and the prescaler phase stay frozen. External edges are also ignored. Counting resumes from the frozen phase when the bit returns to 0.
- R5: A control write with bit 4 = 1 zeroes the counter and the prescaler at that edge. Counting then restarts from 0x0000. A control write with bit 4 = 0 leaves the count untouched. Bit 4 always reads back as 0.
- R6: A single control write that sets both stop (bit 3) and clear (bit 4) leaves the count held at 0x0000, and the control register reads 0x08.
- R7: The counter wraps from 0xFFFF to 0x0000 and keeps counting.
- R8: Reading the upper byte copies the current lower byte into a buffer. The next lower-byte read returns that buffered value, even after the counter has advanced or carried into the upper byte.
- R9: Further upper-byte reads do not refresh the buffer. The buffer stays until a lower-byte read releases it, and later lower-byte reads return the live value.
- R10: Writes to address 1 or address 2 change neither the count nor the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| reg_addr | input | 2 | Register select: 0 control, 1 upper count byte, 2 lower count byte |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; triggers the latch side effects |
| rd_data | output | 8 | Read data for the addressed location |

## Verification
The hardest case to reach is a stale buffer: the upper byte is read, time passes, and the upper byte is read again before the lower byte. A buffer that was wrongly refreshed would show up only in the later lower-byte read. The stimulus runs the counter at full rate and spaces the reads by known idle cycles, so a refreshed value and a held value differ by about twenty counts. A second hard case is a carry between the two reads. It is created by clearing the counter and waiting exactly 255 cycles, so that the upper-byte read catches 0x00FF just before it becomes 0x0100.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DEF_DATA_W  = 8;
    localparam int DEF_PRE_W   = 6;
    localparam int DEF_SEL_W   = 3;
    localparam int DEF_SYNC_N  = 2;

    // control register bit positions
    localparam int BIT_HALT = 3;
    localparam int BIT_CLR  = 4;

    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_CNT_HI = 2'd1,
        A_CNT_LO = 2'd2,
        A_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic                 halt;
        logic [DEF_SEL_W-1:0] sel;
    } ctrl_t;

    function automatic logic sel_is_ext(input logic [DEF_SEL_W-1:0] sel);
        return sel == {DEF_SEL_W{1'b1}};
    endfunction

endpackage

// File: rtl/ptmr_extsync.sv
module ptmr_extsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int PRE_W = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             halt,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_rise,
    output logic             tick
);
    localparam logic [PRE_W:0] ONE = {{PRE_W{1'b0}}, 1'b1};

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W:0]   mask_w;
    logic             div_tick;

    always_ff @(posedge clk) begin
        if (rst || clr)  pre_q <= '0;
        else if (!halt)  pre_q <= pre_q + 1'b1;
    end

    // low k bits of the phase all ones marks the last cycle of a 2^k period
    always_comb begin
        one_hot  = ONE << sel;
        mask_w   = one_hot - ONE;
        div_tick = &(pre_q | ~mask_w[PRE_W-1:0]);
    end

    assign tick = !halt && (ptmr_pkg::sel_is_ext(sel) ? ext_rise : div_tick);
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ptmr_rdlatch.sv
module ptmr_rdlatch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hi,
    input  logic              rd_lo,
    input  logic [DATA_W-1:0] live_lo,
    output logic              held,
    output logic [DATA_W-1:0] buf_lo,
    output logic [DATA_W-1:0] lo_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= 1'b0;
            buf_lo <= '0;
        end else if (rd_lo) begin
            held   <= 1'b0;
        end else if (rd_hi && !held) begin
            held   <= 1'b1;
            buf_lo <= live_lo;
        end
    end

    assign lo_out = held ? buf_lo : live_lo;
endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer
    import ptmr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PRE_W  = DEF_PRE_W,
    parameter int SYNC_N = DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk,
    input  logic [1:0]        reg_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = 2 * DATA_W;
    localparam int SEL_W = DEF_SEL_W;

    reg_addr_e         addr_w;
    ctrl_t             ctrl_q;
    logic              clr_w;
    logic              ext_rise;
    logic              tick;
    logic [CNT_W-1:0]  cnt;
    logic              lat_held;
    logic [DATA_W-1:0] lat_buf;
    logic [DATA_W-1:0] lo_out;
    logic              halt_w;
    logic              unused_wbits;

    assign addr_w       = reg_addr_e'(reg_addr);
    assign clr_w        = wr_en && addr_w == A_CTRL && wr_data[BIT_CLR];
    assign halt_w       = ctrl_q.halt;
    assign unused_wbits = ^wr_data[DATA_W-1:BIT_CLR+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && addr_w == A_CTRL) begin
            ctrl_q.sel  <= wr_data[SEL_W-1:0];
            ctrl_q.halt <= wr_data[BIT_HALT];
        end
    end

    ptmr_extsync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .async_in(ext_clk), .rise(ext_rise)
    );

    ptmr_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst(rst), .clr(clr_w), .halt(ctrl_q.halt),
        .sel(ctrl_q.sel), .ext_rise(ext_rise), .tick(tick)
    );

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr_w), .tick(tick), .cnt(cnt)
    );

    ptmr_rdlatch #(.DATA_W(DATA_W)) u_lat (
        .clk(clk), .rst(rst),
        .rd_hi(rd_en && addr_w == A_CNT_HI),
        .rd_lo(rd_en && addr_w == A_CNT_LO),
        .live_lo(cnt[DATA_W-1:0]),
        .held(lat_held), .buf_lo(lat_buf), .lo_out(lo_out)
    );

    always_comb begin
        rd_data = '0;
        case (addr_w)
            A_CTRL: begin
                rd_data[SEL_W-1:0] = ctrl_q.sel;
                rd_data[BIT_HALT]  = ctrl_q.halt;
            end
            A_CNT_HI: rd_data = cnt[CNT_W-1:DATA_W];
            A_CNT_LO: rd_data = lo_out;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        reg_addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              halt,
    input logic [CNT_W-1:0]  cnt,
    input logic              held,
    input logic [DATA_W-1:0] buf_lo
);
    logic clr_wr;
    assign clr_wr = wr_en && reg_addr == 2'd0 && wr_data[ptmr_pkg::BIT_CLR];

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cnt == '0);

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> cnt == '0);

    // R5
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_addr == 2'd0) |-> rd_data[ptmr_pkg::BIT_CLR] == 1'b0);

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && !clr_wr) |=> cnt == $past(cnt));

    // R7
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !(rd_en && reg_addr == 2'd2)) |=> (held && $stable(buf_lo)));
endmodule

bind ptmr_timer ptmr_chk #(.DATA_W(DATA_W), .CNT_W(2 * DATA_W)) i_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .halt(halt_w), .cnt(cnt), .held(lat_held), .buf_lo(lat_buf)
);

// File: tb/test_ptmr_timer.sv
module test_ptmr_timer;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    ptmr_timer i_ptmr_timer (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // monitor: compare each read against the next expected item
    always @(negedge clk) begin
        if (rd_en && !done) begin
            item_t it;
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty: actual=%02h expected=none", rd_data);
            end else begin
                it = sb.pop_front();
                if (rd_data !== it.exp) begin
                    failures++;
                    $display("FAIL %s addr=%0d actual=%02h expected=%02h",
                             it.tag, reg_addr, rd_data, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(posedge clk);
        #1;
        wr_en    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        reg_addr = a;
        rd_en    = 1'b1;
        @(posedge clk);
        #1;
        rd_en    = 1'b0;
    endtask

    task automatic rd16(input logic [15:0] e, input string tag);
        rd(2'd1, e[15:8], tag);
        rd(2'd2, e[7:0], tag);
    endtask

    task automatic pulse();
        ext_clk = 1'b1;
        idle(3);
        ext_clk = 1'b0;
        idle(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;

        // R1 reset state
        rd16(16'h0000, "R1");
        rd(2'd0, 8'h00, "R1");

        // R2 every divided rate, 200 cycles after a clear
        for (int k = 0; k < 7; k++) begin
            wr(2'd0, 8'h10 | 8'(k));
            idle(200);
            rd16(16'(200 >> k), "R2");
        end

        // R4 stop freezes count and prescaler phase (divide by 4)
        wr(2'd0, 8'h12);
        idle(10);
        wr(2'd0, 8'h0A);
        idle(50);
        rd16(16'd2, "R4");
        wr(2'd0, 8'h02);
        idle(1);
        rd16(16'd3, "R4");

        // R5 clear restarts, clear bit 0 has no effect, reads 0
        wr(2'd0, 8'h10);
        idle(20);
        wr(2'd0, 8'h00);
        idle(9);
        rd16(16'd30, "R5");
        rd(2'd0, 8'h00, "R5");

        // R6 stop and clear together hold at zero
        wr(2'd0, 8'h18);
        idle(30);
        rd16(16'd0, "R6");
        rd(2'd0, 8'h08, "R6");

        // R10 writes to count bytes ignored
        wr(2'd1, 8'h55);
        wr(2'd2, 8'h66);
        rd16(16'd0, "R10");

        // R8 carry between the two byte reads
        wr(2'd0, 8'h10);
        idle(255);
        rd16(16'h00FF, "R8");
        rd(2'd2, 8'h01, "R8");

        // R9 repeated upper reads do not refresh the buffer
        wr(2'd0, 8'h10);
        idle(10);
        rd(2'd1, 8'h00, "R9");
        idle(20);
        rd(2'd1, 8'h00, "R9");
        idle(5);
        rd(2'd2, 8'd10, "R9");
        rd(2'd2, 8'd38, "R9");

        // R7 wrap past 0xFFFF
        wr(2'd0, 8'h10);
        idle(65536 + 5);
        rd16(16'd5, "R7");

        // R3 external clock edges
        wr(2'd0, 8'h17);
        for (int p = 0; p < 5; p++) pulse();
        idle(4);
        rd16(16'd5, "R3");
        // R4 external edges ignored while stopped
        wr(2'd0, 8'h0F);
        pulse();
        pulse();
        idle(4);
        rd16(16'd5, "R4");
        wr(2'd0, 8'h07);
        pulse();
        idle(4);
        rd16(16'd6, "R3");

        idle(3);
        if (sb.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb.size());
        end
        finish_run();
    end
endmodule